// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block sits between instruction decode and a set of execution units. It gives each instruction that writes a register a slot in a circular buffer, and the slot's index serves as that instruction's renamed register number. Execution units return results in any order on a result bus. The block copies them into a safe architectural register file one slot per cycle, strictly in allocation order. A trap or a redirect therefore always sees a register state that matches a single point in the program.

For each architectural register, the safe file keeps a "renamed" flag and the slot number of the newest pending writer of that register. An operand lookup returns one of three answers:

- the committed value, when the register has no pending writer;
- the value of the pending slot, when that slot already holds its result;
- the slot number to wait on, when it does not.

Decode marks the slots allocated after an unresolved conditional branch as speculative. These slots never retire. When the branch resolves as predicted, they become ordinary slots. On a misprediction they are discarded, the allocation pointer returns to the first discarded slot, and the rename flags are rebuilt from the slots that remain.

Allocation is a valid/ready handshake. `alloc_ready` drops when all `DEPTH` slots are in flight, and also during any cycle in which a branch outcome is presented. The result bus is valid-only, because every slot can always accept its own result. Retirement and lookup are plain status outputs. `DEPTH` must be a power of two.

Top module: `rob_retire`

## Requirements
- R1: An allocation handshake (`alloc_valid` and `alloc_ready` high at a clock edge) claims the slot shown on `alloc_tag`. Successive allocations receive consecutive slot numbers modulo `DEPTH`. `alloc_ready` is low while `DEPTH` slots are in flight and while `br_valid` is high.
- R2: A result with `res_valid` high stores `res_data` in slot `res_tag` and marks that slot complete. A slot is incomplete from the moment it is allocated.
- R3: A lookup of a register with no pending writer returns `src_ready`=1 and the committed value.
- R4: A lookup of a register with a pending writer uses the newest such slot. If that slot is complete, the lookup returns `src_ready`=1 and the slot's value. Otherwise it returns `src_ready`=0 and `src_tag` set to that slot number.
- R5: The oldest slot retires when it is complete, and at most one slot retires per cycle. A retiring slot drives `retire_valid`=1 together with its register number and value, and its value is written into the committed file. Retirement follows allocation order whatever the order of results.
- R6: Retiring a slot clears its register's renamed flag only if that slot is still the register's newest writer. When a later writer exists, lookups keep returning that later writer's slot.
- R7: A slot allocated with `alloc_spec`=1 does not retire, and nothing behind it retires, until a branch outcome is presented.
- R8: `br_valid`=1 with `br_mispredict`=0 turns all speculative slots into ordinary ones, and they then retire normally.
- R9: `br_valid`=1 with `br_mispredict`=1 discards every speculative slot. The next allocation receives the first discarded slot number. Lookups then reflect only the surviving writers.
- R10: After reset the buffer is empty, `alloc_ready` is 1, `retire_valid` is 0, and every register reads as committed with value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers an instruction with a destination |
| alloc_ready | output | 1 | A slot can be claimed this cycle |
| alloc_areg | input | $clog2(NUM_AREGS) | Destination architectural register |
| alloc_spec | input | 1 | Instruction follows an unresolved branch |
| alloc_tag | output | $clog2(DEPTH) | Slot (renamed register) given to the offered instruction |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| res_data | input | DATA_W | Result value |
| br_valid | input | 1 | Branch outcome presented this cycle |
| br_mispredict | input | 1 | Outcome was mispredicted |
| src_areg | input | $clog2(NUM_AREGS) | Register to look up |
| src_ready | output | 1 | Lookup value is usable |
| src_value | output | DATA_W | Committed or slot value |
| src_tag | output | $clog2(DEPTH) | Slot to wait on when not ready |
| retire_valid | output | 1 | A slot retires at this edge |
| retire_areg | output | $clog2(NUM_AREGS) | Register being committed |
| retire_data | output | DATA_W | Value being committed |

## Verification
The bench goes after results that arrive in shuffled order while the buffer is full. A design that retired out of order, or retired an incomplete slot, would commit values in the wrong sequence. It also gives the same register two pending writers and retires only the older one; a design that cleared the renamed flag unconditionally would hand the stale committed value to a reader. A result delivered to a slot that is later discarded, followed by a flush, checks that the rename table is rebuilt rather than left pointing at dead slots, and that the reused slot comes back incomplete. Finally, speculative slots whose results are complete must stay unretired until the branch outcome is presented.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Outcome of a source operand lookup.
  typedef enum logic [1:0] {
    SRC_SAFE  = 2'd0,
    SRC_ENTRY = 2'd1,
    SRC_WAIT  = 2'd2
  } src_kind_e;
endpackage

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 3,
  parameter int DATA_W = 16,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_en,
  input  logic [TAG_W-1:0]               alloc_idx,
  input  logic [AREG_W-1:0]              alloc_areg,
  input  logic                           alloc_spec,
  input  logic                           res_en,
  input  logic [TAG_W-1:0]               res_idx,
  input  logic [DATA_W-1:0]              res_data,
  input  logic                           spec_clr,
  output logic [DEPTH-1:0]               valid_q,
  output logic [DEPTH-1:0]               spec_q,
  output logic [DEPTH-1:0][AREG_W-1:0]   areg_q,
  output logic [DEPTH-1:0][DATA_W-1:0]   data_q
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        spec_q[e]  <= 1'b0;
        areg_q[e]  <= '0;
        data_q[e]  <= '0;
      end else begin
        if (res_en && res_idx == TAG_W'(e)) begin
          valid_q[e] <= 1'b1;
          data_q[e]  <= res_data;
        end
        if (spec_clr) spec_q[e] <= 1'b0;
        if (alloc_en && alloc_idx == TAG_W'(e)) begin
          valid_q[e] <= 1'b0;
          spec_q[e]  <= alloc_spec;
          areg_q[e]  <= alloc_areg;
        end
      end
    end
  end

  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> !valid_q[$past(alloc_idx)]); // R2
  AST_RESULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_en && !(alloc_en && alloc_idx == res_idx)) |=> valid_q[$past(res_idx)]); // R2
endmodule

// File: rtl/rob_safe_file.sv
module rob_safe_file #(
  parameter int NUM_AREGS = 8,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 16,
  localparam int AREG_W = $clog2(NUM_AREGS),
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int PTR_W  = TAG_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ret_en,
  input  logic [AREG_W-1:0]            ret_areg,
  input  logic [DATA_W-1:0]            ret_data,
  input  logic [TAG_W-1:0]             ret_tag,
  input  logic                         alloc_en,
  input  logic [AREG_W-1:0]            alloc_areg,
  input  logic [TAG_W-1:0]             alloc_tag,
  input  logic                         flush,
  input  logic [PTR_W-1:0]             scan_start,
  input  logic [PTR_W-1:0]             scan_end,
  input  logic [DEPTH-1:0][AREG_W-1:0] ent_areg,
  input  logic [AREG_W-1:0]            rd_areg,
  output logic                         rd_renamed,
  output logic [DATA_W-1:0]            rd_value,
  output logic [TAG_W-1:0]             rd_tag
);
  logic [NUM_AREGS-1:0]             renamed_q;
  logic [NUM_AREGS-1:0][TAG_W-1:0]  idx_q;
  logic [NUM_AREGS-1:0][DATA_W-1:0] value_q;
  logic [PTR_W-1:0]                 span;

  assign span = scan_end - scan_start;

  for (genvar r = 0; r < NUM_AREGS; r++) begin : g_reg
    logic             found;
    logic [TAG_W-1:0] newest;

    // Rebuild after a flush: newest surviving writer of this register.
    always_comb begin
      found  = 1'b0;
      newest = '0;
      for (int k = 0; k < DEPTH; k++) begin
        logic [TAG_W-1:0] slot;
        slot = TAG_W'(scan_start[TAG_W-1:0] + TAG_W'(k));
        if (k < int'(span) && ent_areg[slot] == AREG_W'(r)) begin
          found  = 1'b1;
          newest = slot;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        renamed_q[r] <= 1'b0;
        idx_q[r]     <= '0;
        value_q[r]   <= '0;
      end else begin
        if (ret_en && ret_areg == AREG_W'(r)) value_q[r] <= ret_data;
        if (flush) begin
          renamed_q[r] <= found;
          idx_q[r]     <= newest;
        end else begin
          if (ret_en && ret_areg == AREG_W'(r) && idx_q[r] == ret_tag)
            renamed_q[r] <= 1'b0;
          if (alloc_en && alloc_areg == AREG_W'(r)) begin
            renamed_q[r] <= 1'b1;
            idx_q[r]     <= alloc_tag;
          end
        end
      end
    end

    AST_ALLOC_RENAMES: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !flush && alloc_areg == AREG_W'(r))
        |=> (renamed_q[r] && idx_q[r] == $past(alloc_tag))); // R4
    AST_OLD_RETIRE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && !flush && ret_areg == AREG_W'(r) && renamed_q[r] && idx_q[r] != ret_tag)
        |=> renamed_q[r]); // R6
  end

  assign rd_renamed = renamed_q[rd_areg];
  assign rd_value   = value_q[rd_areg];
  assign rd_tag     = idx_q[rd_areg];
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int NUM_AREGS = 8,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 16,
  localparam int AREG_W = $clog2(NUM_AREGS),
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int PTR_W  = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [AREG_W-1:0] alloc_areg,
  input  logic              alloc_spec,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              br_valid,
  input  logic              br_mispredict,
  input  logic [AREG_W-1:0] src_areg,
  output logic              src_ready,
  output logic [DATA_W-1:0] src_value,
  output logic [TAG_W-1:0]  src_tag,
  output logic              retire_valid,
  output logic [AREG_W-1:0] retire_areg,
  output logic [DATA_W-1:0] retire_data
);
  logic [PTR_W-1:0] head_q, tail_q, spec_ptr_q, head_nx, count;
  logic             spec_any_q, full, empty, alloc_fire, flush;
  logic [TAG_W-1:0] head_idx;

  logic [DEPTH-1:0]             ent_valid, ent_spec;
  logic [DEPTH-1:0][AREG_W-1:0] ent_areg;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;

  logic              rd_renamed;
  logic [DATA_W-1:0] rd_value;
  logic [TAG_W-1:0]  rd_tag;
  src_kind_e         kind;

  assign count       = tail_q - head_q;
  assign full        = (count == PTR_W'(DEPTH));
  assign empty       = (count == '0);
  assign head_idx    = head_q[TAG_W-1:0];
  assign alloc_tag   = tail_q[TAG_W-1:0];
  assign alloc_ready = !full && !br_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign flush       = br_valid && br_mispredict && spec_any_q;

  assign retire_valid = !empty && ent_valid[head_idx] && !ent_spec[head_idx];
  assign retire_areg  = ent_areg[head_idx];
  assign retire_data  = ent_data[head_idx];
  assign head_nx      = head_q + PTR_W'(retire_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      spec_ptr_q <= '0;
      spec_any_q <= 1'b0;
    end else begin
      head_q <= head_nx;
      if (flush)           tail_q <= spec_ptr_q;
      else if (alloc_fire) tail_q <= tail_q + PTR_W'(1);
      if (br_valid) spec_any_q <= 1'b0;
      else if (alloc_fire && alloc_spec && !spec_any_q) begin
        spec_any_q <= 1'b1;
        spec_ptr_q <= tail_q;
      end
    end
  end

  rob_entries #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_entries (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_fire),
    .alloc_idx (alloc_tag),
    .alloc_areg(alloc_areg),
    .alloc_spec(alloc_spec),
    .res_en    (res_valid),
    .res_idx   (res_tag),
    .res_data  (res_data),
    .spec_clr  (br_valid),
    .valid_q   (ent_valid),
    .spec_q    (ent_spec),
    .areg_q    (ent_areg),
    .data_q    (ent_data)
  );

  rob_safe_file #(.NUM_AREGS(NUM_AREGS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_safe (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_en    (retire_valid),
    .ret_areg  (retire_areg),
    .ret_data  (retire_data),
    .ret_tag   (head_idx),
    .alloc_en  (alloc_fire),
    .alloc_areg(alloc_areg),
    .alloc_tag (alloc_tag),
    .flush     (flush),
    .scan_start(head_nx),
    .scan_end  (spec_ptr_q),
    .ent_areg  (ent_areg),
    .rd_areg   (src_areg),
    .rd_renamed(rd_renamed),
    .rd_value  (rd_value),
    .rd_tag    (rd_tag)
  );

  always_comb begin
    if (!rd_renamed)          kind = SRC_SAFE;
    else if (ent_valid[rd_tag]) kind = SRC_ENTRY;
    else                      kind = SRC_WAIT;
  end

  assign src_ready = (kind != SRC_WAIT);
  assign src_value = (kind == SRC_SAFE) ? rd_value : ent_data[rd_tag];
  assign src_tag   = rd_tag;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PTR_W'(DEPTH)); // R1
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready); // R1
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !retire_valid); // R5
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> (head_q == $past(head_q) + PTR_W'(1))); // R5
  AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> !(spec_any_q && head_q == spec_ptr_q)); // R7
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail_q == $past(spec_ptr_q))); // R9
endmodule

// File: tb/rob_retire_tb.sv
module rob_retire_tb;
  localparam int NA = 8, DEPTH = 8, DW = 16;
  localparam int AW = $clog2(NA), TW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_spec = 0, res_valid = 0, br_valid = 0, br_mispredict = 0;
  logic [AW-1:0] alloc_areg = '0, src_areg = '0;
  logic [TW-1:0] res_tag = '0;
  logic [DW-1:0] res_data = '0;
  logic alloc_ready, src_ready, retire_valid;
  logic [TW-1:0] alloc_tag, src_tag;
  logic [DW-1:0] src_value, retire_data;
  logic [AW-1:0] retire_areg;

  always #5 clk = ~clk;

  rob_retire #(.NUM_AREGS(NA), .DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_areg(alloc_areg),
    .alloc_spec(alloc_spec), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .br_valid(br_valid), .br_mispredict(br_mispredict),
    .src_areg(src_areg), .src_ready(src_ready), .src_value(src_value), .src_tag(src_tag),
    .retire_valid(retire_valid), .retire_areg(retire_areg), .retire_data(retire_data));

  int n_cmp = 0, n_bad = 0, seq = 0, n_spec = 0;
  logic [AW-1:0] m_areg [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  bit            m_done [DEPTH];
  logic [DW-1:0] m_safe [NA];
  int            prog_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Retirement monitor against the in-order program model (R5).
  always @(negedge clk) begin
    if (rst_n && retire_valid) begin
      if (prog_q.size() == 0) chk("R5 retire with nothing pending", 1, 0);
      else begin
        int t;
        t = prog_q.pop_front();
        chk("R5 retire register", 32'(retire_areg), 32'(m_areg[t]));
        chk("R5 retire value", 32'(retire_data), 32'(m_data[t]));
        m_safe[m_areg[t]] = m_data[t];
      end
    end
  end

  task automatic do_alloc(input int areg, input bit spec, output int tag);
    @(negedge clk);
    alloc_valid = 1; alloc_areg = AW'(areg); alloc_spec = spec;
    #1;
    chk("R1 alloc_ready", 32'(alloc_ready), 1);
    tag = int'(alloc_tag);
    m_areg[tag] = AW'(areg);
    m_data[tag] = DW'(16'h1000 + seq * 37);
    m_done[tag] = 0;
    seq++;
    prog_q.push_back(tag);
    if (spec) n_spec++;
    @(posedge clk); #1;
    alloc_valid = 0; alloc_spec = 0;
  endtask

  task automatic give_result(input int tag);
    @(negedge clk);
    res_valid = 1; res_tag = TW'(tag); res_data = m_data[tag];
    m_done[tag] = 1;
    @(posedge clk); #1;
    res_valid = 0;
  endtask

  task automatic resolve(input bit mis);
    @(negedge clk);
    br_valid = 1; br_mispredict = mis;
    #1;
    chk("R1 alloc blocked during branch outcome", 32'(alloc_ready), 0);
    if (mis) repeat (n_spec) void'(prog_q.pop_back());
    n_spec = 0;
    @(posedge clk); #1;
    br_valid = 0; br_mispredict = 0;
  endtask

  task automatic look(input int areg, input string req);
    int newest;
    newest = -1;
    @(negedge clk);
    src_areg = AW'(areg);
    #1;
    foreach (prog_q[i]) if (m_areg[prog_q[i]] == AW'(areg)) newest = prog_q[i];
    if (newest < 0) begin
      chk({req, " committed ready"}, 32'(src_ready), 1);
      chk({req, " committed value"}, 32'(src_value), 32'(m_safe[areg]));
    end else if (m_done[newest]) begin
      chk({req, " slot ready"}, 32'(src_ready), 1);
      chk({req, " slot value"}, 32'(src_value), 32'(m_data[newest]));
    end else begin
      chk({req, " wait"}, 32'(src_ready), 0);
      chk({req, " wait tag"}, 32'(src_tag), 32'(newest));
    end
  endtask

  task automatic drain();
    repeat (3 * DEPTH) @(negedge clk);
    chk("R5 all retired", 32'(prog_q.size()), 0);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int tg, first_spec, r0, r1;
    int ord[DEPTH];
    for (int i = 0; i < NA; i++) m_safe[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R10 reset state
    @(negedge clk);
    chk("R10 alloc_ready", 32'(alloc_ready), 1);
    chk("R10 retire_valid", 32'(retire_valid), 0);
    for (int a = 0; a < NA; a++) look(a, "R10 R3 reset lookup");

    // R1 R4 R5 R6: full buffer, shuffled results, repeated registers
    for (int rnd = 0; rnd < 6; rnd++) begin
      int base;
      base = -1;
      for (int i = 0; i < DEPTH; i++) begin
        do_alloc((i + rnd) % 5, 0, tg);
        if (base < 0) base = tg;
        chk("R1 consecutive tag", 32'(tg), 32'((base + i) % DEPTH));
        ord[i] = tg;
      end
      @(negedge clk);
      chk("R1 full blocks alloc", 32'(alloc_ready), 0);
      for (int a = 0; a < NA; a++) look(a, "R4 pending lookup");
      for (int i = DEPTH - 1; i > 0; i--) begin
        int j, t;
        j = int'($urandom % (i + 1));
        t = ord[i]; ord[i] = ord[j]; ord[j] = t;
      end
      for (int i = 0; i < DEPTH; i++) begin
        give_result(ord[i]);
        look(m_areg[ord[i]], "R4 R6 after result");
      end
      drain();
      for (int a = 0; a < NA; a++) look(a, "R3 committed after drain");
    end

    // R6 explicit: two writers of one register, only the older retires
    do_alloc(1, 0, r0);
    do_alloc(1, 0, r1);
    give_result(r0);
    repeat (4) @(negedge clk);
    src_areg = 1; #1;
    chk("R6 still renamed", 32'(src_ready), 0);
    chk("R6 newer tag kept", 32'(src_tag), 32'(r1));
    give_result(r1);
    drain();
    look(1, "R6 final");

    // R7 R8: speculative slots hold until a correct outcome
    do_alloc(2, 0, r0);
    do_alloc(3, 0, r1);
    ord[0] = r0; ord[1] = r1;
    for (int i = 0; i < 3; i++) begin
      do_alloc((4 + i) % NA, 1, tg);
      ord[2 + i] = tg;
    end
    for (int i = 4; i >= 0; i--) give_result(ord[i]);
    repeat (DEPTH) @(negedge clk);
    chk("R7 speculative slots held", 32'(prog_q.size()), 3);
    chk("R7 no retire before outcome", 32'(retire_valid), 0);
    look(4, "R7 spec value visible");
    resolve(0);
    drain();
    look(5, "R8 committed after resolve");

    // R9: mispredict discards speculative slots and rebuilds renames
    do_alloc(6, 0, r0);
    do_alloc(6, 1, first_spec);
    do_alloc(7, 1, tg);
    give_result(tg);
    do_alloc(0, 1, r1);
    resolve(1);
    look(6, "R9 surviving writer");
    look(7, "R9 discarded writer gone");
    look(0, "R9 discarded writer gone");
    do_alloc(7, 0, tg);
    chk("R9 tail restored", 32'(tg), 32'(first_spec));
    look(7, "R9 reused slot incomplete");
    give_result(tg);
    give_result(r0);
    drain();
    for (int a = 0; a < NA; a++) look(a, "R9 R3 final state");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule